// File: doc/BRIEF.md
# Burst Bus Memory Target Controller

This block sits on the memory side of a processor local bus and answers the bus cycles that the processor starts. The processor raises a cycle-start strobe for one clock. With it come a byte address, a read or write flag and a cache hint. The controller latches the line address and inserts a fixed number of wait states. It then returns one ready strobe per 32-bit doubleword moved. Each strobe is a single-clock access to a simple synchronous memory behind it. Read data passes straight through in the same clock as its strobe. Write data is stored at the clock edge that ends the strobe.

Bursts stay inside one aligned 16-byte line of four doublewords and may start at any of them. The processor's last-transfer signal, sampled with each ready strobe, decides whether more doublewords follow. With the first ready of a read, the controller also reports two things: whether the line may be cached, and whether it should be kept write-back or write-through. Both come from address windows set by parameters. A write carrying the cache hint is a line write-back. It always moves four doublewords, whatever the last-transfer signal says, and no cacheability indication is reported for it.

Top module: `burst_mem_target`

## Requirements
- R1: While reset is asserted and on the first clock after it, `xfer_rdy`, `mem_en`, `mem_we`, `line_cacheable` and `line_writeback` are all low.
- R2: The first `xfer_rdy` of a cycle is high exactly `WAIT_STATES`+1 clocks after the edge that samples `cyc_start`. After that, `xfer_rdy` stays high on every clock until the cycle ends, and each high clock moves one doubleword.
- R3: Transfer k (k = 0..3) of a cycle addresses byte offset 4*(s XOR k) within the latched 16-byte line, where s is `cpu_addr[3:2]` at cycle start. Bits `mem_addr[AW-1:4]` equal the latched `cpu_addr[AW-1:4]`, and `mem_addr[1:0]` is zero.
- R4: In a cycle that is not a write-back, a ready strobe sampled with `cpu_last_n` low is the last one: `xfer_rdy` is low on the next clock.
- R5: A ready strobe sampled with `cpu_last_n` high is followed by another on the next clock, up to a limit of four. After the fourth transfer the cycle ends even if `cpu_last_n` is still high.
- R6: A write cycle started with `cpu_cache_hint` high (a line write-back) always moves exactly four doublewords, whatever `cpu_last_n` does.
- R7: `line_cacheable` is high only together with the first ready strobe of a read cycle whose address lies outside the uncached window (`(addr & NC_MASK) == NC_BASE`). It is low on every other clock, including all clocks of write and write-back cycles.
- R8: `line_writeback` is high only together with the first ready strobe of a read cycle whose address lies outside the write-through window (`(addr & WT_MASK) == WT_BASE`). It is low on every other clock, including all clocks of write-back cycles.
- R9: A `cyc_start` pulse that arrives while a cycle is in progress is ignored. No extra transfer follows the current cycle.
- R10: During a read strobe, `cpu_rdata` equals the memory word at `mem_addr`. During a write strobe, `mem_we` is high and `cpu_wdata` is stored at `mem_addr`.
- R11: A read burst into the uncached window still runs as a burst when `cpu_last_n` is held high: all four doublewords are moved, in the order given by R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_start | input | 1 | One-clock strobe that starts a bus cycle |
| cpu_addr | input | AW | Byte address of the first doubleword, sampled with `cyc_start` |
| cpu_wr | input | 1 | 1 = write cycle, 0 = read cycle, sampled with `cyc_start` |
| cpu_cache_hint | input | 1 | Processor cache hint; on a write it marks a line write-back |
| cpu_last_n | input | 1 | Sampled with each ready: high = more transfers follow, low = last |
| cpu_wdata | input | DW | Write data for the current transfer |
| cpu_rdata | output | DW | Read data for the current transfer |
| xfer_rdy | output | 1 | One-clock ready strobe per doubleword |
| line_cacheable | output | 1 | Line may be cached; valid with the first ready of a read |
| line_writeback | output | 1 | Line kept write-back (1) or write-through (0); valid with the first ready of a read |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory byte address, doubleword aligned |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, combinational from `mem_addr` |

## Verification
The beat counter or the latched start index can go wrong inside the block. If it does, the doubleword order on `mem_addr` leaves the XOR pattern on the second strobe of a burst, or the line bits change between strobes. Either shows up one clock after the fault.

The state register can also go wrong. It then shows as a ready strobe missing after a strobe sampled with last-transfer high, or as one too many after the closing strobe. The bench sees this on the very next clock.

A wrong stored write-back flag shows as a write-back cut short or a read that ignores the last-transfer signal. It appears at the first strobe where the two paths differ.

A wrong region decode shows only on the first strobe of a read. It is caught there by comparing against the address windows.

// File: rtl/burst_tgt_pkg.sv
package burst_tgt_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_XFER = 2'd2
   } tgt_state_e;

   localparam int unsigned LINE_WORDS = 4;
   localparam int unsigned BEAT_W     = 2;
endpackage

// File: rtl/burst_order.sv
// Doubleword index for each beat of a line burst.
module burst_order #(
   parameter bit LINEAR = 1'b0
) (
   input  logic [1:0] start_idx,
   input  logic [1:0] beat,
   output logic [1:0] word_idx
);
   generate
      if (LINEAR) begin : g_wrap
         assign word_idx = start_idx + beat;
      end else begin : g_xor
         // interleaved: 0-4-8-C, 4-0-C-8, 8-C-0-4, C-8-4-0
         assign word_idx = start_idx ^ beat;
      end
   endgenerate
endmodule

// File: rtl/region_decode.sv
// Address window match.
module region_decode #(
   parameter int unsigned    AW   = 32,
   parameter logic [AW-1:0]  BASE = '0,
   parameter logic [AW-1:0]  MASK = '0
) (
   input  logic [AW-1:0] addr,
   output logic          hit
);
   assign hit = ((addr & MASK) == BASE);
endmodule

// File: rtl/burst_mem_target.sv
module burst_mem_target
   import burst_tgt_pkg::*;
#(
   parameter int unsigned   AW           = 32,
   parameter int unsigned   DW           = 32,
   parameter int unsigned   WAIT_STATES  = 1,
   parameter bit            LINEAR_ORDER = 1'b0,
   parameter logic [AW-1:0] NC_BASE      = AW'(32'h0000_0080),
   parameter logic [AW-1:0] NC_MASK      = AW'(32'hFFFF_FF80),
   parameter logic [AW-1:0] WT_BASE      = AW'(32'h0000_0040),
   parameter logic [AW-1:0] WT_MASK      = AW'(32'hFFFF_FFC0)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cyc_start,
   input  logic [AW-1:0] cpu_addr,
   input  logic          cpu_wr,
   input  logic          cpu_cache_hint,
   input  logic          cpu_last_n,
   input  logic [DW-1:0] cpu_wdata,
   output logic [DW-1:0] cpu_rdata,
   output logic          xfer_rdy,
   output logic          line_cacheable,
   output logic          line_writeback,
   output logic          mem_en,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata
);
   localparam int unsigned LINE_W    = AW - 4;
   localparam int unsigned WCW       = (WAIT_STATES > 1) ? $clog2(WAIT_STATES) : 1;
   localparam int unsigned WAIT_LOAD = (WAIT_STATES > 0) ? WAIT_STATES - 1 : 0;

   generate
      if (AW < 8) begin : g_bad_aw
         $error("burst_mem_target: AW must be at least 8");
      end
      if (DW != 32) begin : g_bad_dw
         $error("burst_mem_target: DW must be 32 (doubleword transfers)");
      end
      if (NC_MASK[3:0] != 4'd0 || WT_MASK[3:0] != 4'd0) begin : g_bad_win
         $error("burst_mem_target: region windows must be line aligned");
      end
   endgenerate

   tgt_state_e         state_q;
   logic [LINE_W-1:0]  line_q;
   logic [BEAT_W-1:0]  start_q;
   logic [BEAT_W-1:0]  beat_q;
   logic [WCW-1:0]     wait_q;
   logic               wr_q;
   logic               wb_q;
   logic [BEAT_W-1:0]  word_idx;
   logic               nc_hit;
   logic               wt_hit;
   logic               last_beat;
   logic               first_beat;
   logic               idle_w;

   burst_order #(.LINEAR(LINEAR_ORDER)) u_order (
      .start_idx (start_q),
      .beat      (beat_q),
      .word_idx  (word_idx)
   );

   region_decode #(.AW(AW), .BASE(NC_BASE), .MASK(NC_MASK)) u_nc_win (
      .addr ({line_q, 4'b0000}),
      .hit  (nc_hit)
   );

   region_decode #(.AW(AW), .BASE(WT_BASE), .MASK(WT_MASK)) u_wt_win (
      .addr ({line_q, 4'b0000}),
      .hit  (wt_hit)
   );

   assign idle_w     = (state_q == ST_IDLE);
   assign xfer_rdy   = (state_q == ST_XFER);
   assign first_beat = (beat_q == '0);
   // write-backs ignore the processor's last-transfer signal
   assign last_beat  = (beat_q == BEAT_W'(LINE_WORDS - 1)) || (!wb_q && !cpu_last_n);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         line_q  <= '0;
         start_q <= '0;
         beat_q  <= '0;
         wait_q  <= '0;
         wr_q    <= 1'b0;
         wb_q    <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (cyc_start) begin
                  line_q  <= cpu_addr[AW-1:4];
                  start_q <= cpu_addr[3:2];
                  beat_q  <= '0;
                  wr_q    <= cpu_wr;
                  wb_q    <= cpu_wr && cpu_cache_hint;
                  wait_q  <= WCW'(WAIT_LOAD);
                  state_q <= (WAIT_STATES == 0) ? ST_XFER : ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (wait_q == '0) state_q <= ST_XFER;
               else              wait_q  <= wait_q - 1'b1;
            end
            ST_XFER: begin
               if (last_beat) state_q <= ST_IDLE;
               else           beat_q  <= beat_q + 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign line_cacheable = xfer_rdy && first_beat && !wr_q && !nc_hit;
   assign line_writeback = xfer_rdy && first_beat && !wr_q && !wt_hit;

   assign mem_en    = xfer_rdy;
   assign mem_we    = xfer_rdy && wr_q;
   assign mem_addr  = {line_q, word_idx, 2'b00};
   assign mem_wdata = cpu_wdata;
   assign cpu_rdata = mem_rdata;
endmodule

// File: rtl/burst_mem_target_chk.sv
module burst_mem_target_chk #(
   parameter int unsigned AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          st_idle,
   input logic          cyc_start,
   input logic          cpu_wr,
   input logic          cpu_cache_hint,
   input logic          cpu_last_n,
   input logic          xfer_rdy,
   input logic          mem_en,
   input logic          mem_we,
   input logic          line_cacheable,
   input logic          line_writeback,
   input logic [AW-1:0] mem_addr
);
   logic [2:0] cnt_c;
   logic       wb_c;
   logic       wr_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_c <= '0;
         wb_c  <= 1'b0;
         wr_c  <= 1'b0;
      end else begin
         if (st_idle) cnt_c <= '0;
         else if (xfer_rdy) cnt_c <= cnt_c + 1'b1;
         if (st_idle && cyc_start) begin
            wb_c <= cpu_wr && cpu_cache_hint;
            wr_c <= cpu_wr;
         end
      end
   end

   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> !xfer_rdy && !mem_en && !mem_we && !line_cacheable && !line_writeback);

   a_r2_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_rdy && cnt_c < 3'd3 && (wb_c || cpu_last_n) |=> xfer_rdy);

   a_r3_same_line: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_rdy && $past(xfer_rdy) |->
         mem_addr[AW-1:4] == $past(mem_addr[AW-1:4]) && mem_addr[3:2] != $past(mem_addr[3:2]));

   a_r4_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_rdy && !cpu_last_n && !wb_c |=> !xfer_rdy);

   a_r5_max_four: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_rdy |-> cnt_c < 3'd4);

   a_r6_wb_fourth_ends: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_rdy && wb_c && cnt_c == 3'd3 |=> !xfer_rdy);

   a_r7_cacheable_first_read: assert property (@(posedge clk) disable iff (!rst_n)
      line_cacheable |-> xfer_rdy && cnt_c == 3'd0 && !wr_c);

   a_r8_policy_first_read: assert property (@(posedge clk) disable iff (!rst_n)
      line_writeback |-> xfer_rdy && cnt_c == 3'd0 && !wr_c);
endmodule

bind burst_mem_target burst_mem_target_chk #(.AW(AW)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .st_idle        (idle_w),
   .cyc_start      (cyc_start),
   .cpu_wr         (cpu_wr),
   .cpu_cache_hint (cpu_cache_hint),
   .cpu_last_n     (cpu_last_n),
   .xfer_rdy       (xfer_rdy),
   .mem_en         (mem_en),
   .mem_we         (mem_we),
   .line_cacheable (line_cacheable),
   .line_writeback (line_writeback),
   .mem_addr       (mem_addr)
);

// File: tb/burst_mem_target_tb.sv
module burst_mem_target_tb;
   localparam int WS = 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cyc_start = 1'b0;
   logic [31:0] cpu_addr = '0;
   logic        cpu_wr = 1'b0;
   logic        cpu_cache_hint = 1'b0;
   logic        cpu_last_n = 1'b0;
   logic [31:0] cpu_wdata = '0;
   logic [31:0] cpu_rdata;
   logic        xfer_rdy, line_cacheable, line_writeback, mem_en, mem_we;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [31:0] mem [0:63];

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   burst_mem_target #(.WAIT_STATES(WS)) u_dut (
      .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cpu_addr(cpu_addr),
      .cpu_wr(cpu_wr), .cpu_cache_hint(cpu_cache_hint), .cpu_last_n(cpu_last_n),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .xfer_rdy(xfer_rdy),
      .line_cacheable(line_cacheable), .line_writeback(line_writeback),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   assign mem_rdata = mem[mem_addr[7:2]];
   always @(posedge clk) if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // runs one bus cycle; nreq = transfers the processor asks for
   task automatic run_cycle(input logic [31:0] addr, input bit wr, input bit hint,
                            input int nreq, input bit inject);
      bit wb    = wr && hint;
      int nexp  = wb ? 4 : ((nreq > 4) ? 4 : nreq);
      bit exp_c = !wr && !((addr & 32'hFFFF_FF80) == 32'h0000_0080);
      bit exp_w = !wr && !((addr & 32'hFFFF_FFC0) == 32'h0000_0040);
      logic [31:0] ea;
      @(negedge clk);
      cyc_start = 1'b1; cpu_addr = addr; cpu_wr = wr; cpu_cache_hint = hint;
      @(negedge clk);
      cyc_start = 1'b0;
      for (int w = 0; w < WS; w++) begin
         chk("R2 no ready during wait", {31'd0, xfer_rdy}, 32'd0);
         @(negedge clk);
      end
      for (int k = 0; k < nexp; k++) begin
         ea = {addr[31:4], 4'b0} | ({30'd0, addr[3:2] ^ 2'(k)} << 2);
         chk("R2 ready strobe", {31'd0, xfer_rdy}, 32'd1);
         chk("R3 burst address", mem_addr, ea);
         chk("R7 cacheable", {31'd0, line_cacheable}, (k == 0) ? {31'd0, exp_c} : 32'd0);
         chk("R8 write policy", {31'd0, line_writeback}, (k == 0) ? {31'd0, exp_w} : 32'd0);
         if (!wr) chk("R10 read data", cpu_rdata, mem[ea[7:2]]);
         else     chk("R10 write enable", {31'd0, mem_we}, 32'd1);
         cpu_last_n = (k < nreq - 1);
         cpu_wdata  = 32'h5A00_0000 | (32'(k) << 8) | ea;
         if (inject && k == 1) begin
            cyc_start = 1'b1; cpu_addr = 32'h0000_00F0;
         end
         @(negedge clk);
         cyc_start = 1'b0;
      end
      chk(wb ? "R6 write-back ends after four" : "R4 R5 cycle ends",
          {31'd0, xfer_rdy}, 32'd0);
      if (wr) begin
         for (int k = 0; k < nexp; k++) begin
            ea = {addr[31:4], 4'b0} | ({30'd0, addr[3:2] ^ 2'(k)} << 2);
            chk(wb ? "R6 R10 line stored" : "R10 word stored", mem[ea[7:2]],
                32'h5A00_0000 | (32'(k) << 8) | ea);
         end
      end
      for (int w = 0; w < WS + 2; w++) begin
         @(negedge clk);
         chk(inject ? "R9 strobe ignored" : "R4 bus idle", {31'd0, xfer_rdy}, 32'd0);
      end
      cpu_last_n = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = 32'hA000_0000 + 32'(i);
      repeat (3) @(negedge clk);
      chk("R1 reset ready", {31'd0, xfer_rdy}, 32'd0);
      chk("R1 reset mem_en", {31'd0, mem_en}, 32'd0);
      chk("R1 reset cacheable", {31'd0, line_cacheable}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset", {29'd0, xfer_rdy, mem_we, line_writeback}, 32'd0);
      run_cycle(32'h0000_0000, 1'b0, 1'b1, 4, 1'b0); // R3 order 0-4-8-C
      run_cycle(32'h0000_0014, 1'b0, 1'b1, 4, 1'b0); // R3 order 4-0-C-8
      run_cycle(32'h0000_0048, 1'b0, 1'b1, 4, 1'b0); // R8 write-through window
      run_cycle(32'h0000_008C, 1'b0, 1'b0, 4, 1'b0); // R11 uncached burst
      run_cycle(32'h0000_0024, 1'b0, 1'b0, 1, 1'b0); // R4 single read
      run_cycle(32'h0000_0038, 1'b0, 1'b1, 2, 1'b0); // R4 stop after two
      run_cycle(32'h0000_0004, 1'b0, 1'b1, 6, 1'b0); // R5 capped at four
      run_cycle(32'h0000_0064, 1'b1, 1'b1, 1, 1'b0); // R6 write-back
      run_cycle(32'h0000_0030, 1'b1, 1'b0, 1, 1'b0); // R10 single write
      run_cycle(32'h0000_00A8, 1'b0, 1'b1, 4, 1'b1); // R9 strobe mid-cycle
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule